// File: doc/BRIEF.md
# Shader Operand Swizzle and Modifier Stage

This stage prepares one four-lane operand for a shader datapath. Each lane is a 32-bit IEEE single-precision word, and the lanes are ordered x, y, z, w with indices 0 to 3. A control word picks the source vector. The source is either the temporary-register vector or the constant vector. The control word also selects one of two paths:
- The ALU path applies a relative lane swizzle, then an absolute-value modifier, then a negate modifier, then an optional saturation to [0.0, 1.0]. It produces write enables from a four-bit lane mask.
- The fetch path places the fetched lanes by a 3-bit code per destination lane. A code can pick a source lane, write 0.0, write 1.0, or suppress the write.

The result is registered. It appears one cycle after a valid strobe, together with four per-lane write enables. A three-state machine tracks what the output register holds:
- `ST_IDLE` means no result is being presented.
- `ST_ALU` means an ALU-path result is presented.
- `ST_FETCH` means a fetch-path result is presented.

From any state, a strobe with the mode bit clear moves to `ST_ALU`. A strobe with the mode bit set moves to `ST_FETCH`. No strobe returns to `ST_IDLE`.

Control word layout (bit positions):
- `[7:0]`: ALU swizzle.
- `[11:8]`: write mask.
- `[12]`: negate.
- `[13]`: absolute value.
- `[14]`: clamp.
- `[15]`: source select.
- `[16]`: mode.
- `[28:17]`: fetch lane codes.

Top module: `opd_prep_unit`

## Requirements
- R1: The result, write enables and `out_valid_o` update on the clock edge after `in_valid_i` is sampled high; on an edge where `in_valid_i` is low, `out_valid_o` and `we_o` go to 0 in the next cycle.
- R2: Control bit 15 selects the source: 1 takes `tmp_data_i`, 0 takes `cst_data_i`. This applies in both modes.
- R3: In ALU mode (bit 16 = 0), output lane i takes source lane (s_i + i) mod 4, where s_i is control bits [2i+1:2i]. All-zero bits give x, y, z, w unchanged.
- R4: In ALU mode, abs (bit 13) clears each lane's sign bit, then negate (bit 12) inverts it. With both set, every sign bit is 1. The other 31 bits are unchanged.
- R5: In ALU mode, `we_o` equals control bits [11:8], where bit 8 is lane x and bit 11 is lane w.
- R6: In ALU mode with clamp (bit 14) set, each lane is saturated after the modifiers:
  - A negative value or NaN gives 0x00000000.
  - A value above 1.0, including +inf, gives 0x3F800000.
  - Any other value is kept.
- R7: In fetch mode (bit 16 = 1), lane i uses code c_i = control bits [17+3i+2:17+3i]. Codes 0..3 copy source lane x, y, z, w. Code 4 writes 0x00000000 and code 5 writes 0x3F800000. For codes 0..5, `we_o[i]` is 1.
- R8: In fetch mode, codes 6 and 7 clear `we_o[i]` and leave that lane's data at 0.
- R9: In fetch mode, swizzle, negate, abs, clamp and the write mask have no effect on `res_o` or `we_o`.
- R10: After reset, `out_valid_o` = 0, `we_o` = 0 and `res_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Strobe: process this control word and source |
| ctl_i | input | 29 | Control word, fields as laid out above |
| tmp_data_i | input | 128 | Temporary-register source vector, lane x in bits [31:0] |
| cst_data_i | input | 128 | Constant source vector, lane x in bits [31:0] |
| out_valid_o | output | 1 | Registered result is presented |
| we_o | output | 4 | Per-lane write enables, bit 0 = lane x |
| res_o | output | 128 | Registered result vector, lane x in bits [31:0] |

## Verification
The assertions assume the following about the inputs:
- `ctl_i` and the data ports are stable and known whenever `in_valid_i` is high.
- The mode bit fully determines which fields matter, so neither path reads the other path's fields.

Each bench task changes inputs only at the falling edge and holds them for exactly one rising edge. This means every strobe pairs with a single control word. The bench deliberately sets unused-path fields to non-zero values, for example the modifiers in fetch mode, so that their lack of effect can be observed.

// File: rtl/opd_pkg.sv
package opd_pkg;
    localparam int unsigned LANES    = 4;
    localparam int unsigned LANE_W   = 32;
    localparam int unsigned VEC_W    = LANES * LANE_W;
    localparam int unsigned SWZ_W    = $clog2(LANES);
    localparam int unsigned FCODE_W  = 3;

    // control word field positions
    localparam int unsigned F_SWZ    = 0;
    localparam int unsigned F_MASK   = F_SWZ + LANES * SWZ_W;
    localparam int unsigned F_NEG    = F_MASK + LANES;
    localparam int unsigned F_ABS    = F_NEG + 1;
    localparam int unsigned F_CLAMP  = F_ABS + 1;
    localparam int unsigned F_SEL    = F_CLAMP + 1;
    localparam int unsigned F_MODE   = F_SEL + 1;
    localparam int unsigned F_FSWZ   = F_MODE + 1;
    localparam int unsigned CTL_W    = F_FSWZ + LANES * FCODE_W;

    localparam logic [LANE_W-1:0] FP_ZERO = 32'h0000_0000;
    localparam logic [LANE_W-1:0] FP_ONE  = 32'h3F80_0000;

    localparam logic [FCODE_W-1:0] FC_ZERO = 3'd4;
    localparam logic [FCODE_W-1:0] FC_ONE  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALU   = 2'd1,
        ST_FETCH = 2'd2
    } opd_state_e;
endpackage

// File: rtl/opd_alu_swz.sv
module opd_alu_swz
    import opd_pkg::*;
(
    input  logic [VEC_W-1:0]         vec_i,
    input  logic [LANES*SWZ_W-1:0]   swz_i,
    output logic [VEC_W-1:0]         vec_o
);
    // relative swizzle: each field is an offset from the lane's own index
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SWZ_W-1:0] src_idx;
        assign src_idx = swz_i[g*SWZ_W +: SWZ_W] + SWZ_W'(g);
        assign vec_o[g*LANE_W +: LANE_W] = vec_i[src_idx*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/opd_modifier.sv
module opd_modifier
    import opd_pkg::*;
(
    input  logic [VEC_W-1:0] vec_i,
    input  logic             neg_i,
    input  logic             abs_i,
    input  logic             clamp_i,
    output logic [VEC_W-1:0] vec_o
);
    function automatic logic [LANE_W-1:0] saturate(input logic [LANE_W-1:0] v);
        logic is_nan;
        is_nan = (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
        if (v[LANE_W-1] || is_nan)
            return FP_ZERO;
        else if (v > FP_ONE)
            return FP_ONE;
        else
            return v;
    endfunction

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] raw;
        logic              sgn;
        logic [LANE_W-1:0] signed_v;
        assign raw      = vec_i[g*LANE_W +: LANE_W];
        // abs first, negate second, on the sign bit only
        assign sgn      = (abs_i ? 1'b0 : raw[LANE_W-1]) ^ neg_i;
        assign signed_v = {sgn, raw[LANE_W-2:0]};
        assign vec_o[g*LANE_W +: LANE_W] = clamp_i ? saturate(signed_v) : signed_v;
    end
endmodule

// File: rtl/opd_fetch_place.sv
module opd_fetch_place
    import opd_pkg::*;
(
    input  logic [VEC_W-1:0]           vec_i,
    input  logic [LANES*FCODE_W-1:0]   code_i,
    output logic [VEC_W-1:0]           vec_o,
    output logic [LANES-1:0]           we_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [FCODE_W-1:0] code;
        assign code = code_i[g*FCODE_W +: FCODE_W];
        always_comb begin
            vec_o[g*LANE_W +: LANE_W] = FP_ZERO;
            we_o[g] = 1'b0;
            if (code[FCODE_W-1] == 1'b0) begin
                vec_o[g*LANE_W +: LANE_W] = vec_i[code[SWZ_W-1:0]*LANE_W +: LANE_W];
                we_o[g] = 1'b1;
            end else if (code == FC_ZERO) begin
                vec_o[g*LANE_W +: LANE_W] = FP_ZERO;
                we_o[g] = 1'b1;
            end else if (code == FC_ONE) begin
                vec_o[g*LANE_W +: LANE_W] = FP_ONE;
                we_o[g] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/opd_prep_unit.sv
module opd_prep_unit
    import opd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid_i,
    input  logic [CTL_W-1:0]     ctl_i,
    input  logic [VEC_W-1:0]     tmp_data_i,
    input  logic [VEC_W-1:0]     cst_data_i,
    output logic                 out_valid_o,
    output logic [LANES-1:0]     we_o,
    output logic [VEC_W-1:0]     res_o
);
    opd_state_e        state_q, state_d;
    logic [VEC_W-1:0]  src_vec;
    logic [VEC_W-1:0]  swz_vec;
    logic [VEC_W-1:0]  mod_vec;
    logic [VEC_W-1:0]  fch_vec;
    logic [LANES-1:0]  fch_we;
    logic [VEC_W-1:0]  res_q;
    logic [LANES-1:0]  we_q;
    logic              is_fetch;

    assign is_fetch = ctl_i[F_MODE];
    assign src_vec  = ctl_i[F_SEL] ? tmp_data_i : cst_data_i;

    opd_alu_swz u_swz (
        .vec_i (src_vec),
        .swz_i (ctl_i[F_SWZ +: LANES*SWZ_W]),
        .vec_o (swz_vec)
    );

    opd_modifier u_mod (
        .vec_i   (swz_vec),
        .neg_i   (ctl_i[F_NEG]),
        .abs_i   (ctl_i[F_ABS]),
        .clamp_i (ctl_i[F_CLAMP]),
        .vec_o   (mod_vec)
    );

    opd_fetch_place u_fch (
        .vec_i  (src_vec),
        .code_i (ctl_i[F_FSWZ +: LANES*FCODE_W]),
        .vec_o  (fch_vec),
        .we_o   (fch_we)
    );

    // next state
    always_comb begin
        state_d = ST_IDLE;
        if (in_valid_i)
            state_d = is_fetch ? ST_FETCH : ST_ALU;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // result and enable registers, loaded on a strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            we_q  <= '0;
        end else if (in_valid_i) begin
            res_q <= is_fetch ? fch_vec : mod_vec;
            we_q  <= is_fetch ? fch_we  : ctl_i[F_MASK +: LANES];
        end
    end

    // outputs
    always_comb begin
        out_valid_o = 1'b0;
        we_o        = '0;
        unique case (state_q)
            ST_IDLE: begin
                out_valid_o = 1'b0;
                we_o        = '0;
            end
            ST_ALU, ST_FETCH: begin
                out_valid_o = 1'b1;
                we_o        = we_q;
            end
            default: begin
                out_valid_o = 1'b0;
                we_o        = '0;
            end
        endcase
    end

    assign res_o = res_q;
endmodule

// File: rtl/opd_prep_chk.sv
module opd_prep_chk
    import opd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid_i,
    input logic [CTL_W-1:0]   ctl_i,
    input logic               out_valid_o,
    input logic [LANES-1:0]   we_o,
    input logic [VEC_W-1:0]   res_o
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!out_valid_o && we_o == '0));

    a_r5_mask_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !ctl_i[F_MODE]) |=> (we_o == $past(ctl_i[F_MASK +: LANES])));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        a_r6_clamp_range: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && !ctl_i[F_MODE] && ctl_i[F_CLAMP])
            |=> (res_o[g*LANE_W +: LANE_W] <= FP_ONE));

        a_r8_code_hole: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && ctl_i[F_MODE] && ctl_i[F_FSWZ + g*FCODE_W + 1 +: 2] == 2'b11)
            |=> (!we_o[g] && res_o[g*LANE_W +: LANE_W] == FP_ZERO));

        a_r7_const_one: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && ctl_i[F_MODE] && ctl_i[F_FSWZ + g*FCODE_W +: FCODE_W] == FC_ONE)
            |=> (we_o[g] && res_o[g*LANE_W +: LANE_W] == FP_ONE));
    end
endmodule

bind opd_prep_unit opd_prep_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .ctl_i       (ctl_i),
    .out_valid_o (out_valid_o),
    .we_o        (we_o),
    .res_o       (res_o)
);

// File: tb/sim_opd_prep_unit.sv
module sim_opd_prep_unit;
    import opd_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid_i = 1'b0;
    logic [CTL_W-1:0]   ctl_i = '0;
    logic [VEC_W-1:0]   tmp_data_i = '0;
    logic [VEC_W-1:0]   cst_data_i = '0;
    logic               out_valid_o;
    logic [LANES-1:0]   we_o;
    logic [VEC_W-1:0]   res_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    opd_prep_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .ctl_i(ctl_i),
        .tmp_data_i(tmp_data_i), .cst_data_i(cst_data_i),
        .out_valid_o(out_valid_o), .we_o(we_o), .res_o(res_o)
    );

    localparam logic [31:0] LX = 32'h1111_1111, LY = 32'h2222_2222,
                            LZ = 32'h3333_3333, LW = 32'h4444_4444;
    localparam logic [31:0] KX = 32'h5555_0001, KY = 32'h5555_0002,
                            KZ = 32'h5555_0003, KW = 32'h5555_0004;

    function automatic logic [CTL_W-1:0] mk_ctl(
        input logic [7:0] swz, input logic [3:0] mask, input logic neg,
        input logic abs_f, input logic clamp, input logic sel, input logic mode,
        input logic [11:0] fswz);
        return {fswz, mode, sel, clamp, abs_f, neg, mask, swz};
    endfunction

    task automatic chk(input string tag, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one strobe, then sample after the capturing edge
    task automatic issue(input logic [CTL_W-1:0] c);
        @(negedge clk);
        ctl_i = c;
        in_valid_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 valid", VEC_W'(out_valid_o), '0);
        chk("R10 we", VEC_W'(we_o), '0);
        chk("R10 res", res_o, '0);
    endtask

    task automatic t_swizzle();
        tmp_data_i = {LW, LZ, LY, LX};
        issue(mk_ctl(8'h00, 4'hF, 0, 0, 0, 1, 0, 12'h0));
        chk("R1 valid after strobe", VEC_W'(out_valid_o), VEC_W'(1));
        chk("R3 identity", res_o, {LW, LZ, LY, LX});
        issue(mk_ctl(8'hFF, 4'hF, 0, 0, 0, 1, 0, 12'h0));
        chk("R3 all offsets 3", res_o, {LZ, LY, LX, LW});
        issue(mk_ctl(8'h6C, 4'hF, 0, 0, 0, 1, 0, 12'h0));
        chk("R3 broadcast x", res_o, {LX, LX, LX, LX});
    endtask

    task automatic t_select();
        tmp_data_i = {LW, LZ, LY, LX};
        cst_data_i = {KW, KZ, KY, KX};
        issue(mk_ctl(8'h00, 4'hF, 0, 0, 0, 0, 0, 12'h0));
        chk("R2 const file", res_o, {KW, KZ, KY, KX});
        issue(mk_ctl(8'h00, 4'hF, 0, 0, 0, 0, 1, {3'd3, 3'd2, 3'd1, 3'd0}));
        chk("R2 const in fetch mode", res_o, {KW, KZ, KY, KX});
    endtask

    task automatic t_modifiers();
        tmp_data_i = {32'h8000_0000, 32'h0000_0000, 32'hC000_0000, 32'h3F80_0000};
        issue(mk_ctl(8'h00, 4'hF, 1, 0, 0, 1, 0, 12'h0));
        chk("R4 negate", res_o, {32'h0000_0000, 32'h8000_0000, 32'h4000_0000, 32'hBF80_0000});
        issue(mk_ctl(8'h00, 4'hF, 0, 1, 0, 1, 0, 12'h0));
        chk("R4 abs", res_o, {32'h0000_0000, 32'h0000_0000, 32'h4000_0000, 32'h3F80_0000});
        issue(mk_ctl(8'h00, 4'hF, 1, 1, 0, 1, 0, 12'h0));
        chk("R4 neg of abs", res_o, {32'h8000_0000, 32'h8000_0000, 32'hC000_0000, 32'hBF80_0000});
    endtask

    task automatic t_mask();
        tmp_data_i = {LW, LZ, LY, LX};
        issue(mk_ctl(8'h00, 4'h5, 0, 0, 0, 1, 0, 12'hFFF));
        chk("R5 mask 0101", VEC_W'(we_o), VEC_W'(4'h5));
        issue(mk_ctl(8'h00, 4'h8, 0, 0, 0, 1, 0, 12'h0));
        chk("R5 mask 1000", VEC_W'(we_o), VEC_W'(4'h8));
    endtask

    task automatic t_clamp();
        tmp_data_i = {32'h3E80_0000, 32'h7FC0_0000, 32'hBF00_0000, 32'h4000_0000};
        issue(mk_ctl(8'h00, 4'hF, 0, 0, 1, 1, 0, 12'h0));
        chk("R6 sat mix", res_o, {32'h3E80_0000, 32'h0, 32'h0, 32'h3F80_0000});
        tmp_data_i = {32'h3F80_0000, 32'h7F80_0000, 32'h8000_0000, 32'h3F00_0000};
        issue(mk_ctl(8'h00, 4'hF, 0, 0, 1, 1, 0, 12'h0));
        chk("R6 sat edges", res_o, {32'h3F80_0000, 32'h3F80_0000, 32'h0, 32'h3F00_0000});
        issue(mk_ctl(8'h00, 4'hF, 1, 1, 1, 1, 0, 12'h0));
        chk("R6 sat after negabs", res_o, '0);
    endtask

    task automatic t_fetch();
        tmp_data_i = {LW, LZ, LY, LX};
        issue(mk_ctl(8'h00, 4'h0, 0, 0, 0, 1, 1, {3'd7, 3'd5, 3'd4, 3'd2}));
        chk("R7 data", res_o, {32'h0, 32'h3F80_0000, 32'h0, LZ});
        chk("R8 we code7", VEC_W'(we_o), VEC_W'(4'b0111));
        issue(mk_ctl(8'h00, 4'h0, 0, 0, 0, 1, 1, {3'd1, 3'd6, 3'd0, 3'd3}));
        chk("R7 lane pick", res_o, {LY, 32'h0, LX, LW});
        chk("R8 we code6", VEC_W'(we_o), VEC_W'(4'b1011));
    endtask

    task automatic t_fetch_ignore();
        tmp_data_i = {32'hC000_0000, 32'h4100_0000, 32'h8000_0001, 32'h7FC0_0000};
        issue(mk_ctl(8'hFF, 4'h0, 1, 1, 1, 1, 1, {3'd3, 3'd2, 3'd1, 3'd0}));
        chk("R9 data untouched", res_o, {32'hC000_0000, 32'h4100_0000, 32'h8000_0001, 32'h7FC0_0000});
        chk("R9 we ignores mask", VEC_W'(we_o), VEC_W'(4'hF));
    endtask

    task automatic t_idle();
        issue(mk_ctl(8'h00, 4'hF, 0, 0, 0, 1, 0, 12'h0));
        @(negedge clk);
        chk("R1 valid drops", VEC_W'(out_valid_o), '0);
        chk("R1 we drops", VEC_W'(we_o), '0);
    endtask

    initial begin
        #1;
        t_reset();
        #25 rst_n = 1'b1;
        t_reset();
        t_swizzle();
        t_select();
        t_modifiers();
        t_mask();
        t_clamp();
        t_fetch();
        t_fetch_ignore();
        t_idle();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule